// File: doc/BRIEF.md
# Atomic Compare-and-Exchange Memory Unit

This unit performs one atomic compare-and-swap on a single memory word. It drives a simple request/response memory port. A start pulse hands it an address, an expected value and a replacement value. The unit first reads the word at that address and compares it with the expected value. It then always issues one write to the same address. On a match the replacement value is written. On a mismatch the word just read is written back unchanged.

A lock output rises with the read and falls only after the write has been acknowledged. Other masters sharing the memory can therefore never see a locked read that is not followed by its locked write. When the sequence ends, the unit pulses a done flag for one cycle and reports two results. The match flag tells whether the swap took place. The accumulator output carries the expected value after a success, or the value found in memory after a failure. The operand width is a parameter: 32 bits by default, and 64 bits is supported.

Top module: `atomic_cas_unit`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o, lock_o, mem_req_o, mem_we_o and match_o are 0 and acc_o is all zeros.
- R2: A start_i seen at a clock edge while idle makes the unit present, from the next cycle on, a read: mem_req_o=1, mem_we_o=0, mem_addr_o equal to the sampled addr_i, with lock_o=1. The read is held until mem_rvalid_i is 1 at an edge.
- R3: The read word is compared with the sampled expect_i over the full DW bits. When they are equal, the write that follows carries the sampled new_i, and match_o=1 and acc_o equals expect_i.
- R4: When they differ in any bit, the write carries the read word unchanged, match_o=0 and acc_o equals the read word.
- R5: Every read is followed in the next cycle by exactly one write to the same address (mem_req_o=1, mem_we_o=1), whatever the comparison result. The write is held until mem_wack_i is 1 at an edge, and mem_addr_o is stable while mem_req_o stays high.
- R6: lock_o is 1 in every cycle in which mem_req_o is 1, from the first read cycle through the write-acknowledge cycle, and it is 0 in the done cycle.
- R7: done_o is a single-cycle pulse in the cycle after the write acknowledge. match_o and acc_o are valid in that cycle and hold until the next accepted start. busy_o is 1 from the cycle after start through the done cycle.
- R8: A start_i arriving while busy_o=1, including the done cycle, is ignored: it produces no extra read or write, and the unit is idle in the cycle after done.
- R9: addr_i, expect_i and new_i are sampled only with an accepted start. Changing them during an operation does not alter its address, its written data or its results.
- R10: The default DW is 32. A mismatch confined to the most significant bit is detected as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| addr_i | input | AW | Target address |
| expect_i | input | DW | Expected (accumulator) value |
| new_i | input | DW | Replacement value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| match_o | output | 1 | Comparison matched; swap performed |
| acc_o | output | DW | Resulting accumulator value |
| lock_o | output | 1 | Memory lock, covers read through write |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with mem_rvalid_i |
| mem_rvalid_i | input | 1 | Read response |
| mem_wack_i | input | 1 | Write acknowledge |

## Verification
The read request and the lock appear one cycle after the accepting start edge. The bench samples them at the falling edge following that edge. The write is presented in the cycle after the edge where the read response arrives. done_o, match_o and acc_o appear one cycle after the edge where the write is acknowledged. The bench polls falling edges until done_o appears and compares the results in that exact cycle. The memory model in the bench delays each response randomly by zero to three cycles, so these relative timings are exercised at varying distances from start. The model also counts reads and writes per operation, and every bus request is checked for lock coverage.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } cas_state_e;
endpackage

// File: rtl/cas_sequencer.sv
module cas_sequencer
  import cas_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rvalid_i,
  input  logic       wack_i,
  output cas_state_e state_o
);
  cas_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)  state_d = ST_READ;
      ST_READ:  if (rvalid_i) state_d = ST_WRITE;
      ST_WRITE: if (wack_i)   state_d = ST_DONE;
      ST_DONE:                state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cas_operand_reg.sv
module cas_operand_reg #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] expect_i,
  input  logic [DW-1:0] new_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] expect_o,
  output logic [DW-1:0] new_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      expect_o <= '0;
      new_o    <= '0;
    end else if (load_i) begin
      addr_o   <= addr_i;
      expect_o <= expect_i;
      new_o    <= new_i;
    end
  end
endmodule

// File: rtl/cas_result.sv
module cas_result #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_fire_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] expect_i,
  input  logic [DW-1:0] new_i,
  output logic          match_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] acc_o
);
  logic [DW-1:0] rd_q;
  logic          match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      match_q <= 1'b0;
    end else if (rd_fire_i) begin
      rd_q    <= rdata_i;
      match_q <= (rdata_i == expect_i);
    end
  end

  // failed compare writes the old word back; acc reports what memory held
  assign wdata_o = match_q ? new_i    : rd_q;
  assign acc_o   = match_q ? expect_i : rd_q;
  assign match_o = match_q;
endmodule

// File: rtl/atomic_cas_unit.sv
module atomic_cas_unit
  import cas_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] expect_i,
  input  logic [DW-1:0] new_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          match_o,
  output logic [DW-1:0] acc_o,
  output logic          lock_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rvalid_i,
  input  logic          mem_wack_i
);
  cas_state_e    state;
  logic          load, rd_fire, in_read, in_write;
  logic [DW-1:0] exp_q, new_q;

  cas_sequencer u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .rvalid_i(mem_rvalid_i),
    .wack_i  (mem_wack_i),
    .state_o (state)
  );

  assign in_read  = (state == ST_READ);
  assign in_write = (state == ST_WRITE);
  assign load     = (state == ST_IDLE) && start_i;
  assign rd_fire  = in_read && mem_rvalid_i;

  cas_operand_reg #(.DW(DW), .AW(AW)) u_opr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (addr_i),
    .expect_i(expect_i),
    .new_i   (new_i),
    .addr_o  (mem_addr_o),
    .expect_o(exp_q),
    .new_o   (new_q)
  );

  cas_result #(.DW(DW)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_fire_i(rd_fire),
    .rdata_i (mem_rdata_i),
    .expect_i(exp_q),
    .new_i   (new_q),
    .match_o (match_o),
    .wdata_o (mem_wdata_o),
    .acc_o   (acc_o)
  );

  assign mem_req_o = in_read || in_write;
  assign mem_we_o  = in_write;
  assign lock_o    = in_read || in_write;
  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_DONE);
endmodule

// File: rtl/cas_checker.sv
module cas_checker #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          match_o,
  input logic [DW-1:0] acc_o,
  input logic          lock_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic          mem_rvalid_i,
  input logic          mem_wack_i
);
  a_r2_read_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (mem_req_o && !mem_we_o && lock_o));

  a_r6_lock_covers_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> lock_o);

  a_r5_write_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_rvalid_i) |=> (mem_req_o && mem_we_o));

  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o));

  a_r7_done_after_wack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_wack_i) |=> (done_o && !lock_o && !mem_req_o));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r4_writeback_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_rvalid_i) |=>
      (match_o || (mem_wdata_o == $past(mem_rdata_i) && acc_o == $past(mem_rdata_i))));

  a_r3_acc_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_rvalid_i) |=> (!match_o || acc_o == $past(mem_rdata_i)));

  a_r7_results_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(acc_o) && $stable(match_o)));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !lock_o && !done_o));
endmodule

bind atomic_cas_unit cas_checker #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/atomic_cas_unit_bench.sv
`timescale 1ns/1ps
module atomic_cas_unit_bench;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int MW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] expv = '0, newv = '0;
  logic          busy, done, match, lock, req, we;
  logic [DW-1:0] acc, wdata;
  logic [AW-1:0] maddr;
  logic [DW-1:0] rdata = '0;
  logic          rvalid = 1'b0, wack = 1'b0;

  logic [DW-1:0] mem [MW];
  int            wait_cnt = 0;
  int            rd_cnt = 0, wr_cnt = 0;
  int            checks = 0, failures = 0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  atomic_cas_unit #(.DW(DW), .AW(AW)) u_atomic_cas_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .expect_i(expv), .new_i(newv), .busy_o(busy), .done_o(done),
    .match_o(match), .acc_o(acc), .lock_o(lock), .mem_req_o(req),
    .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_rvalid_i(rvalid), .mem_wack_i(wack)
  );

  // memory model with random response latency
  always @(posedge clk) begin
    rvalid <= 1'b0;
    wack   <= 1'b0;
    if (rst_n && req && !rvalid && !wack) begin
      if (wait_cnt == 0) begin
        if (!we) begin
          rdata  <= mem[maddr[3:0]];
          rvalid <= 1'b1;
          rd_cnt <= rd_cnt + 1;
        end else begin
          mem[maddr[3:0]] <= wdata;
          wack   <= 1'b1;
          wr_cnt <= wr_cnt + 1;
        end
        wait_cnt <= $urandom_range(0, 3);
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // R6: every bus request cycle must be locked
  always @(negedge clk) begin
    if (rst_n && req) chk(lock, "R6", "lock during request", lock, 1);
  end

  task automatic run_op(input logic [3:0] a, input logic [DW-1:0] e, input logic [DW-1:0] n,
                        input bit disturb, input bit spur);
    logic [DW-1:0] old, exp_acc, exp_mem;
    bit            exp_match;
    int            rd0, wr0, guard;
    old       = mem[a];
    exp_match = (old == e);
    exp_acc   = exp_match ? e : old;
    exp_mem   = exp_match ? n : old;
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk);
    addr  = {{(AW-4){1'b0}}, a};
    expv  = e;
    newv  = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req && !we && lock && busy, "R2", "read issued", {req, we, lock, busy}, 4'b1011);
    chk(maddr == {{(AW-4){1'b0}}, a}, "R2", "read address", maddr, a);
    if (disturb) begin
      // R9: inputs change mid-operation, R8: start ignored while busy
      addr  = $urandom;
      expv  = $urandom;
      newv  = $urandom;
      start = 1'b1;
    end
    guard = 0;
    while (!done && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    chk(done, "R7", "done seen", done, 1);
    chk(!lock && !req, "R6", "lock low at done", lock, 0);
    chk(match == exp_match, exp_match ? "R3" : "R4", "match", match, exp_match);
    chk(acc == exp_acc, exp_match ? "R3" : "R4", "acc", acc, exp_acc);
    chk(mem[a] == exp_mem, exp_match ? "R3" : "R4", "memory word", mem[a], exp_mem);
    chk(rd_cnt - rd0 == 1, "R5", "one read", rd_cnt - rd0, 1);
    chk(wr_cnt - wr0 == 1, "R5", "one write", wr_cnt - wr0, 1);
    if (spur) start = 1'b1;  // R8: start during done cycle
    @(negedge clk);
    start = 1'b0;
    chk(!done && !busy, "R7", "done single pulse", {done, busy}, 0);
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !req, "R8", "no extra operation", {busy, req}, 0);
    chk(rd_cnt - rd0 == 1 && wr_cnt - wr0 == 1, "R8", "access counts after spurious start",
        rd_cnt - rd0 + wr_cnt - wr0, 2);
    chk(acc == exp_acc && match == exp_match, "R7", "results held", acc, exp_acc);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < MW; i++) mem[i] = $urandom;
    #1;
    chk(!busy && !done && !lock && !req && !we && !match && acc == '0, "R1", "reset outputs",
        {busy, done, lock, req, we, match}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !lock && !req && acc == '0, "R1", "after reset release",
        {busy, done, lock, req}, 0);

    run_op(4'd3, mem[3], 32'hCAFE_0001, 1'b0, 1'b0);              // R3 hit
    run_op(4'd3, 32'h1234_5678, 32'hDEAD_BEEF, 1'b0, 1'b0);       // R4 miss
    run_op(4'd5, mem[5] ^ 32'h8000_0000, 32'h0, 1'b0, 1'b0);      // R10 msb-only miss
    run_op(4'd6, mem[6] ^ 32'h0000_0001, 32'h0, 1'b0, 1'b0);      // R4 lsb-only miss
    run_op(4'd7, mem[7], 32'h5555_AAAA, 1'b1, 1'b1);              // R9 R8 hit with disturbance
    run_op(4'd8, ~mem[8], 32'h5555_AAAA, 1'b1, 1'b1);             // R9 R8 miss with disturbance
    run_op(4'd0, mem[0], mem[0], 1'b0, 1'b0);                     // R3 swap with same value

    for (int k = 0; k < 60; k++) begin
      logic [3:0]    a;
      logic [DW-1:0] e;
      a = 4'($urandom_range(0, MW - 1));
      e = ($urandom_range(0, 1) == 1) ? mem[a] : DW'($urandom);
      run_op(a, e, DW'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule